// File: doc/BRIEF.md
# Table-Driven Memory Init Sequencer

This block brings a DRAM controller out of reset by replaying a fixed list of register writes on a simple request/ready register master port. One `start_i` pulse begins a run. If the init status byte shows that another agent has already prepared memory, the run ends at once. Otherwise the block reads a configuration word to learn the memory layout. It then opens two lock gates, the clock/strap block first and the controller second. Each gate takes a magic write followed by reads that repeat until the readback equals one. After that the block walks its entry table.

Each table entry is one of four kinds. A plain write goes to the controller base plus the entry offset. A pause waits a number of microseconds. A type word is replaced according to the layout and merged with strap bits. An end marker finishes the run. A microsecond tick comes from a prescaler sized by the clock frequency in MHz. `busy_o` stays high for the whole run, and `done_o` pulses once when it finishes.

Top module: `meminit_seq`

## Requirements
- R1: After reset the block is idle: `reg_req_o`, `busy_o` and `done_o` are low, and no request is raised while `busy_o` is low.
- R2: When `start_i` arrives in idle with bit 7 of `init_status_i` set, no register transfer takes place and `done_o` is high in the cycle after the start edge.
- R3: The first transfer of a run is a read of `CTRL_BASE+0x4`. Its bits [3:2] and bit 6 pick the layout: 2'b10 with bit 6 set gives 1Gx16, 2'b10 with bit 6 clear gives 512Mx32, 2'b11 gives 1Gx32, and any other value gives 512Mx16.
- R4: Next comes a write of 0x1688A8A8 to `STRAP_BASE`, followed by reads of `STRAP_BASE` that repeat until the read data equals 1.
- R5: Only after that does a write of 0xFC600309 go to `CTRL_BASE`, followed by reads of `CTRL_BASE` that repeat until the read data equals 1.
- R6: A plain table entry writes its data to `CTRL_BASE` plus its 16-bit offset, and entries run in table order.
- R7: A pause entry with data d holds off the next transfer for d×15 microseconds, where one microsecond is `CLK_MHZ` clock cycles.
- R8: A type entry first reads `STRAP_BASE+0x70`. It then writes to `CTRL_BASE` plus its offset a word that is 0xD89 for 1Gx16, 0xC8D for 1Gx32, and otherwise the entry's data. That word is ORed with strap bits [3:2] moved up to bits [5:4].
- R9: After the end entry, `done_o` is high for exactly one cycle and `busy_o` is low in that cycle. `busy_o` is high in every cycle from the one after the start edge until then.
- R10: A request whose `reg_ready_i` is low stays raised in the next cycle with the same address, write data and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a run when idle |
| init_status_i | input | 8 | Status byte; bit 7 means memory is already initialised |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| reg_req_o | output | 1 | Register transfer request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W | Transfer address |
| reg_wdata_o | output | 32 | Write data |
| reg_ready_i | input | 1 | Transfer completes in a cycle where request and ready are both high |
| reg_rdata_i | input | 32 | Read data, valid in the completing cycle of a read |

## Verification
Runs are made with configuration words covering every layout code, with bit 6 set and clear under code 2'b10, and with random words. These runs tell apart the four type-word substitutions and show that bit 6 matters only under one code. Strap values and the number of readbacks that fail before the unlocks succeed are random. This shows that the strap bits land in [5:4], and that the block stays in each poll loop exactly until it reads a 1. The ready response stalls at random, which exercises request holding. A run with the already-initialised status bit set tells the skip path apart from a normal run. The measured gaps around the pause entries tell the microsecond scaling apart from an unscaled count.

// File: rtl/meminit_pkg.sv
package meminit_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [1:0] {K_WR, K_DLY, K_TYPE, K_END} kind_e;

   typedef struct packed {
      kind_e              kind;
      logic [15:0]        off;
      logic [WORD_W-1:0]  data;
   } entry_t;

   typedef enum logic [1:0] {
      LAY_512X16, LAY_1GX16, LAY_512X32, LAY_1GX32
   } layout_e;

   function automatic layout_e decode_layout(logic [WORD_W-1:0] cfg);
      layout_e l;
      case (cfg[3:2])
         2'b10:   l = cfg[6] ? LAY_1GX16 : LAY_512X32;
         2'b11:   l = LAY_1GX32;
         default: l = LAY_512X16;
      endcase
      return l;
   endfunction

   function automatic logic [WORD_W-1:0] type_word(layout_e l,
                                                   logic [WORD_W-1:0] dflt,
                                                   logic [WORD_W-1:0] strap);
      logic [WORD_W-1:0] w;
      case (l)
         LAY_1GX16: w = 32'h0000_0D89;
         LAY_1GX32: w = 32'h0000_0C8D;
         default:   w = dflt;
      endcase
      return w | {26'd0, strap[3:2], 4'd0};
   endfunction

endpackage

// File: rtl/meminit_rom.sv
module meminit_rom
   import meminit_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx_i,
   output entry_t           ent_o
);

   always_comb begin
      case (int'(idx_i))
         0: ent_o = '{K_WR,   16'h0008, 32'h00A1_0307};
         1: ent_o = '{K_DLY,  16'h0000, 32'd1};
         2: ent_o = '{K_WR,   16'h006C, 32'h0080_8080};
         3: ent_o = '{K_TYPE, 16'h0004, 32'h0000_04A9};
         4: ent_o = '{K_WR,   16'h0010, 32'h2A31_1C20};
         5: ent_o = '{K_WR,   16'h0034, 32'h0000_0001};
         6: ent_o = '{K_DLY,  16'h0000, 32'd1};
         7: ent_o = '{K_WR,   16'h0028, 32'h0000_0003};
         8: ent_o = '{K_WR,   16'h000C, 32'h0000_5A10};
         default: ent_o = '{K_END, 16'h0000, 32'h0};
      endcase
   end

endmodule

// File: rtl/meminit_tick.sv
module meminit_tick #(
   parameter int CLK_MHZ = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);

   generate
      if (CLK_MHZ == 1) begin : g_direct
         assign tick_o = en_i;
      end else begin : g_count
         localparam int PW = $clog2(CLK_MHZ);
         logic [PW-1:0] pre_q;
         assign tick_o = en_i && (pre_q == PW'(CLK_MHZ - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           pre_q <= '0;
            else if (!en_i || tick_o) pre_q <= '0;
            else                  pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/meminit_seq.sv
module meminit_seq
   import meminit_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          CLK_MHZ   = 250,
   parameter int          IDX_W     = 4,
   parameter int          DLY_W     = 24,
   parameter int          DLY_REPS  = 15,
   parameter int          SKIP_BIT  = 7,
   parameter logic [31:0] CTRL_BASE = 32'h1E6E_0000,
   parameter logic [31:0] STRAP_OFS = 32'h0000_2000,
   parameter logic [31:0] STRAP_REG = 32'h0000_0070,
   parameter logic [31:0] UNLOCK_A  = 32'h1688_A8A8,
   parameter logic [31:0] UNLOCK_B  = 32'hFC60_0309
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [7:0]        init_status_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              reg_req_o,
   output logic              reg_we_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic [WORD_W-1:0] reg_wdata_o,
   input  logic              reg_ready_i,
   input  logic [WORD_W-1:0] reg_rdata_i
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_BASE);
   localparam logic [ADDR_W-1:0] A_STRAP = ADDR_W'(CTRL_BASE + STRAP_OFS);
   localparam logic [ADDR_W-1:0] A_SREG  = ADDR_W'(CTRL_BASE + STRAP_OFS + STRAP_REG);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(CTRL_BASE + 32'h4);

   generate
      if (CLK_MHZ < 1)             begin : g_bad_clk  $error("CLK_MHZ must be >= 1"); end
      if (ADDR_W < 17)             begin : g_bad_addr $error("ADDR_W too narrow"); end
      if (SKIP_BIT > 7)            begin : g_bad_skip $error("SKIP_BIT out of range"); end
      if (DLY_W < 5 || DLY_W > 32) begin : g_bad_dly  $error("DLY_W out of range"); end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_CFG, S_UA_W, S_UA_P, S_UB_W, S_UB_P,
      S_TAB, S_DLY, S_STRAP, S_TYPE, S_DONE
   } state_e;

   state_e             state_q;
   logic [IDX_W-1:0]   idx_q;
   logic [DLY_W-1:0]   dly_q;
   layout_e            lay_q;
   logic [WORD_W-1:0]  strap_q;
   entry_t             ent;
   logic               tick;
   logic               xfer;

   meminit_rom #(.IDX_W(IDX_W)) rom_i (.idx_i(idx_q), .ent_o(ent));

   meminit_tick #(.CLK_MHZ(CLK_MHZ)) tick_i (
      .clk(clk), .rst_n(rst_n), .en_i(state_q == S_DLY), .tick_o(tick));

   assign xfer   = reg_req_o && reg_ready_i;
   assign done_o = (state_q == S_DONE);
   assign busy_o = (state_q != S_IDLE) && (state_q != S_DONE);

   always_comb begin
      reg_req_o   = 1'b0;
      reg_we_o    = 1'b0;
      reg_addr_o  = '0;
      reg_wdata_o = '0;
      case (state_q)
         S_CFG:   begin reg_req_o = 1'b1; reg_addr_o = A_CFG; end
         S_UA_W:  begin reg_req_o = 1'b1; reg_we_o = 1'b1;
                        reg_addr_o = A_STRAP; reg_wdata_o = UNLOCK_A; end
         S_UA_P:  begin reg_req_o = 1'b1; reg_addr_o = A_STRAP; end
         S_UB_W:  begin reg_req_o = 1'b1; reg_we_o = 1'b1;
                        reg_addr_o = A_CTRL; reg_wdata_o = UNLOCK_B; end
         S_UB_P:  begin reg_req_o = 1'b1; reg_addr_o = A_CTRL; end
         S_TAB:   if (ent.kind == K_WR) begin
                     reg_req_o   = 1'b1;
                     reg_we_o    = 1'b1;
                     reg_addr_o  = A_CTRL + ADDR_W'(ent.off);
                     reg_wdata_o = ent.data;
                  end
         S_STRAP: begin reg_req_o = 1'b1; reg_addr_o = A_SREG; end
         S_TYPE:  begin reg_req_o = 1'b1; reg_we_o = 1'b1;
                        reg_addr_o  = A_CTRL + ADDR_W'(ent.off);
                        reg_wdata_o = type_word(lay_q, ent.data, strap_q); end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         dly_q   <= '0;
         lay_q   <= LAY_512X16;
         strap_q <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (start_i) begin
               idx_q   <= '0;
               state_q <= init_status_i[SKIP_BIT] ? S_DONE : S_CFG;
            end
            S_CFG: if (xfer) begin
               lay_q   <= decode_layout(reg_rdata_i);
               state_q <= S_UA_W;
            end
            S_UA_W: if (xfer) state_q <= S_UA_P;
            S_UA_P: if (xfer && reg_rdata_i == 32'd1) state_q <= S_UB_W;
            S_UB_W: if (xfer) state_q <= S_UB_P;
            S_UB_P: if (xfer && reg_rdata_i == 32'd1) state_q <= S_TAB;
            S_TAB: case (ent.kind)
               K_WR:   if (xfer) idx_q <= idx_q + 1'b1;
               K_DLY:  begin
                          dly_q   <= DLY_W'(ent.data[DLY_W-1:0] * DLY_W'(DLY_REPS));
                          state_q <= S_DLY;
                       end
               K_TYPE: state_q <= S_STRAP;
               default: state_q <= S_DONE;
            endcase
            S_DLY: if (dly_q == '0) begin
               idx_q   <= idx_q + 1'b1;
               state_q <= S_TAB;
            end else if (tick) begin
               dly_q <= dly_q - 1'b1;
            end
            S_STRAP: if (xfer) begin
               strap_q <= reg_rdata_i;
               state_q <= S_TYPE;
            end
            S_TYPE: if (xfer) begin
               idx_q   <= idx_q + 1'b1;
               state_q <= S_TAB;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/meminit_seq_chk.sv
module meminit_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [7:0]        init_status_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              reg_req_o,
   input logic              reg_we_o,
   input logic [ADDR_W-1:0] reg_addr_o,
   input logic [31:0]       reg_wdata_o,
   input logic              reg_ready_i
);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && !reg_ready_i |=> reg_req_o && $stable(reg_addr_o)
                                   && $stable(reg_wdata_o) && $stable(reg_we_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !reg_req_o);

   // R2
   skip_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !done_o && init_status_i[7] |=> done_o && !reg_req_o);

endmodule

bind meminit_seq meminit_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_status_i(init_status_i),
   .busy_o(busy_o), .done_o(done_o), .reg_req_o(reg_req_o), .reg_we_o(reg_we_o),
   .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_ready_i(reg_ready_i));

// File: tb/meminit_seq_tb_top.sv
module meminit_seq_tb_top;

   localparam logic [31:0] CTRL  = 32'h1E6E_0000;
   localparam logic [31:0] STRAP = CTRL + 32'h2000;
   localparam int          MHZ   = 250;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  init_status_i = 8'h00;
   logic        busy_o, done_o, reg_req_o, reg_we_o;
   logic [31:0] reg_addr_o, reg_wdata_o;
   logic        reg_ready_i = 1'b0;
   logic [31:0] reg_rdata_i = 32'h0;

   always #2 clk = ~clk;

   meminit_seq #(.CLK_MHZ(MHZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_status_i(init_status_i),
      .busy_o(busy_o), .done_o(done_o), .reg_req_o(reg_req_o), .reg_we_o(reg_we_o),
      .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
      .reg_ready_i(reg_ready_i), .reg_rdata_i(reg_rdata_i));

   int tests = 0, fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // register port model and transfer log
   logic [31:0] cfg_v, strap_v;
   int          pa, pb, ca, cb;
   int          n_x;
   logic        lg_we   [64];
   logic [31:0] lg_addr [64];
   logic [31:0] lg_data [64];
   int          lg_cyc  [64];

   always @(negedge clk) begin
      reg_ready_i = 1'b0;
      if (rst_n && reg_req_o) begin
         reg_ready_i = ($urandom_range(0, 1) == 1);
         if (reg_ready_i) begin
            if (!reg_we_o) begin
               if (reg_addr_o == CTRL + 32'h4)       reg_rdata_i = cfg_v;
               else if (reg_addr_o == STRAP + 32'h70) reg_rdata_i = strap_v;
               else if (reg_addr_o == STRAP) begin
                  reg_rdata_i = (ca < pa) ? 32'h0 : 32'h1; ca++;
               end else if (reg_addr_o == CTRL) begin
                  reg_rdata_i = (cb < pb) ? 32'h2 : 32'h1; cb++;
               end else reg_rdata_i = 32'hDEAD_BEEF;
            end
            if (n_x < 64) begin
               lg_we[n_x]   = reg_we_o;
               lg_addr[n_x] = reg_addr_o;
               lg_data[n_x] = reg_we_o ? reg_wdata_o : 32'h0;
               lg_cyc[n_x]  = cyc;
            end
            n_x++;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // expected transfer list
   int          e_n;
   logic        e_we   [64];
   logic [31:0] e_addr [64];
   logic [31:0] e_data [64];
   int          e_dly  [4];
   int          e_ndly;

   task automatic add(input logic we, input logic [31:0] a, input logic [31:0] d);
      e_we[e_n] = we; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
   endtask

   function automatic logic [31:0] exp_type(input logic [31:0] cfg, input logic [31:0] strap);
      logic [31:0] w;
      w = 32'h0000_04A9;
      if (cfg[3:2] == 2'b11)                 w = 32'h0000_0C8D;
      else if (cfg[3:2] == 2'b10 && cfg[6])  w = 32'h0000_0D89;
      return w | ((strap & 32'hC) << 2);
   endfunction

   task automatic build_expect();
      e_n = 0; e_ndly = 0;
      add(1'b0, CTRL + 32'h4, 32'h0);                       // R3
      add(1'b1, STRAP, 32'h1688_A8A8);                      // R4
      for (int i = 0; i <= pa; i++) add(1'b0, STRAP, 32'h0);
      add(1'b1, CTRL, 32'hFC60_0309);                       // R5
      for (int i = 0; i <= pb; i++) add(1'b0, CTRL, 32'h0);
      add(1'b1, CTRL + 32'h0008, 32'h00A1_0307);            // R6
      e_dly[e_ndly++] = e_n;                                // R7
      add(1'b1, CTRL + 32'h006C, 32'h0080_8080);
      add(1'b0, STRAP + 32'h70, 32'h0);                     // R8
      add(1'b1, CTRL + 32'h0004, exp_type(cfg_v, strap_v));
      add(1'b1, CTRL + 32'h0010, 32'h2A31_1C20);
      add(1'b1, CTRL + 32'h0034, 32'h0000_0001);
      e_dly[e_ndly++] = e_n;
      add(1'b1, CTRL + 32'h0028, 32'h0000_0003);
      add(1'b1, CTRL + 32'h000C, 32'h0000_5A10);
   endtask

   task automatic run(input logic [31:0] cfg, input logic [31:0] strap);
      bit busy_ok;
      int guard;
      cfg_v = cfg; strap_v = strap;
      pa = $urandom_range(0, 3); pb = $urandom_range(0, 3);
      ca = 0; cb = 0; n_x = 0;
      build_expect();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      busy_ok = 1'b1; guard = 0;
      while (!done_o && guard < 20000) begin
         if (!busy_o) busy_ok = 1'b0;
         @(negedge clk); guard++;
      end
      chk(guard < 20000, "R9 run finishes", guard, 20000);
      chk(busy_ok, "R9 busy held during run", busy_ok, 1);
      chk(!busy_o, "R9 busy low with done", busy_o, 0);
      @(negedge clk);
      chk(!done_o, "R9 done is one cycle", done_o, 0);
      chk(n_x == e_n, "R6 transfer count", n_x, e_n);
      for (int i = 0; i < e_n && i < n_x; i++) begin
         chk(lg_we[i] == e_we[i], "R3/R4/R5/R6/R8 direction", lg_we[i], e_we[i]);
         chk(lg_addr[i] == e_addr[i], "R3/R4/R5/R6/R8 address", lg_addr[i], e_addr[i]);
         if (e_we[i])
            chk(lg_data[i] == e_data[i], "R4/R5/R6/R8 write data", lg_data[i], e_data[i]);
      end
      for (int k = 0; k < e_ndly; k++) begin
         int j, gap;
         j = e_dly[k];
         if (j < n_x) begin
            gap = lg_cyc[j] - lg_cyc[j-1];
            chk(gap >= 15 * MHZ && gap <= 15 * MHZ + 40, "R7 pause length", gap, 15 * MHZ);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      n_x = 0; cfg_v = 0; strap_v = 0; pa = 0; pb = 0; ca = 0; cb = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!reg_req_o && !busy_o && !done_o, "R1 reset idle",
          {29'd0, reg_req_o, busy_o, done_o}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!reg_req_o && !busy_o, "R1 idle without start", {30'd0, reg_req_o, busy_o}, 32'h0);

      // R2 skip path
      init_status_i = 8'h80; n_x = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(done_o, "R2 done after skip start", done_o, 1);
      chk(!busy_o, "R2 busy low on skip", busy_o, 0);
      repeat (5) @(negedge clk);
      chk(n_x == 0, "R2 no transfers on skip", n_x, 0);
      init_status_i = 8'h7F;   // other bits must not skip

      // directed layouts R3/R8
      run(32'h0000_0000, 32'h0000_0000);
      run(32'h0000_0004, 32'h0000_000C);
      run(32'h0000_0008, 32'h0000_0004);
      run(32'h0000_0048, 32'h0000_0008);
      run(32'h0000_000C, 32'hFFFF_FFF3);
      run(32'hFFFF_FFBB, 32'h0000_0004);
      // random configs and straps
      for (int r = 0; r < 3; r++) run($urandom, $urandom);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(4 * 190000);
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected run end", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule